// File: doc/BRIEF.md
# RC Wake-up Timer Register

This block is a one-bit I/O register that turns a single open-drain pin into a slow wake-up timer. The pin is wired to ground through a capacitor and to the supply through a resistor. Software writes 0 to switch on the pull-down, which drains the capacitor. It then writes 1 to turn the pull-down off, and the capacitor charges through the resistor.

A Schmitt-buffered copy of the pin enters the block. It is resynchronised to the core clock and watched for a low-to-high transition. When that transition is seen with the pull-down off, the block emits a one-cycle wake-up interrupt. The same pulse also goes to the suspend sequencer as a wake request. The charge time is set by the external resistor and capacitor values, which gives a periodic wake-up with very low average power.

Reads of the register return the pin level as the core sees it, not the value that was written. The analog network and the Schmitt buffer lie outside the block.

Top module: `rc_wake_timer_reg`

## Requirements
- R1: While reset is asserted and after it is released, `pin_drive_low` is 0 (pin released, pin high), `wake_irq` and `wake_req` are 0, and the synchronised pin level starts at 1.
- R2: A write (`io_wr`=1) to address 0x22 with `io_wdata[0]`=0 sets `pin_drive_low` to 1 from the next clock edge.
- R3: A write to address 0x22 with `io_wdata[0]`=1 clears `pin_drive_low` to 0 from the next clock edge.
- R4: Writes to any other address leave `pin_drive_low` unchanged. Bits 7 to 1 of the write data have no effect.
- R5: A read (`io_rd`=1) at address 0x22 returns on `io_rdata` the pin level after a two-flop synchronizer in bit 0, with bits 7 to 1 equal to 0.
- R6: When no read at address 0x22 is in progress, `io_rdata` is 0.
- R7: A 0-to-1 change of the synchronised pin level while `pin_drive_low` is 0 raises `wake_irq`. It is high in the cycle after the second clock edge that samples the pin high.
- R8: A rising pin while `pin_drive_low` is 1 never raises `wake_irq`.
- R9: `wake_req` equals `wake_irq` in every cycle.
- R10: `wake_irq` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data, only bit 0 is used |
| io_rdata | output | 8 | Read data, pin level in bit 0 |
| pin_in | input | 1 | Schmitt-buffered pin level, asynchronous |
| pin_drive_low | output | 1 | 1 turns on the open-drain pull-down |
| wake_irq | output | 1 | One-cycle wake-up interrupt pulse |
| wake_req | output | 1 | Wake request to the suspend sequencer |

## Verification
The assertions assume that reset is released in step with `clk`, that each write strobe lasts one cycle, and that `pin_in` is only sampled through the synchronizer. They do not assume any relation between the pin and the driver.

The stimulus changes every bus input and the pin on the falling clock edge, so the values the design and the bench model sample are settled. The pin model drops the pin half a cycle after the pull-down turns on. After release it raises the pin once a programmable charge delay has passed. A separate glitch input lets the bench force the pin high while the pull-down is on, which exercises the case where a rise must be ignored.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  // Open-drain driver state held in the control flop
  typedef enum logic {
    DRV_RELEASE   = 1'b0,
    DRV_DISCHARGE = 1'b1
  } rcw_drv_e;

  localparam logic RCW_PIN_RESET_LVL = 1'b1;
endpackage

// File: rtl/rcw_bus_decode.sv
module rcw_bus_decode #(
  parameter int             ADDR_W   = 8,
  parameter int             DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h22
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              pin_level,
  output logic              wr_hit,
  output logic              wr_bit,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - 1;

  logic sel;
  logic unused_wdata;

  assign sel          = (io_addr == REG_ADDR);
  assign wr_hit       = io_wr & sel;
  assign wr_bit       = io_wdata[0];
  assign unused_wdata = ^io_wdata[DATA_W-1:1];

  always_comb begin
    rdata = '0;
    if (io_rd && sel) begin
      rdata = {{PAD_W{1'b0}}, pin_level};
    end
  end
endmodule

// File: rtl/rcw_drv_reg.sv
module rcw_drv_reg
  import rcw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic drive_low
);
  rcw_drv_e drv_q;
  rcw_drv_e drv_d;
  logic     drv_en;

  assign drv_en = wr_hit;

  always_comb begin
    drv_d = drv_q;
    if (drv_en) begin
      drv_d = wr_bit ? DRV_RELEASE : DRV_DISCHARGE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= DRV_RELEASE;
    end else if (drv_en) begin
      drv_q <= drv_d;
    end
  end

  assign drive_low = (drv_q == DRV_DISCHARGE);
endmodule

// File: rtl/rcw_sync.sv
module rcw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= RST_VAL;
        end else begin
          chain_q[i] <= chain_d[i];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rcw_rise_det.sv
module rcw_rise_det
  import rcw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic armed,
  output logic pulse
);
  logic prev_q;
  logic prev_d;

  assign prev_d = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RCW_PIN_RESET_LVL;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign pulse = armed & level & ~prev_q;
endmodule

// File: rtl/rc_wake_timer_reg.sv
module rc_wake_timer_reg
  import rcw_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h22,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              pin_in,
  output logic              pin_drive_low,
  output logic              wake_irq,
  output logic              wake_req
);
  logic wr_hit;
  logic wr_bit;
  logic pin_level;
  logic rise;

  rcw_bus_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
  ) u_decode (
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .pin_level(pin_level),
    .wr_hit   (wr_hit),
    .wr_bit   (wr_bit),
    .rdata    (io_rdata)
  );

  rcw_drv_reg u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .wr_bit   (wr_bit),
    .drive_low(pin_drive_low)
  );

  rcw_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(RCW_PIN_RESET_LVL)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pin_level)
  );

  rcw_rise_det u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .level(pin_level),
    .armed(~pin_drive_low),
    .pulse(rise)
  );

  assign wake_irq = rise;
  assign wake_req = rise;
endmodule

// File: rtl/rcw_wake_chk.sv
module rcw_wake_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic [DATA_W-1:0] io_wdata,
  input logic              pin_drive_low,
  input logic              wake_irq
);
  // R2
  wr0_discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == REG_ADDR && !io_wdata[0]) |=> pin_drive_low);

  // R3
  wr1_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == REG_ADDR && io_wdata[0]) |=> !pin_drive_low);

  // R4
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == REG_ADDR) |=> $stable(pin_drive_low));

  // R8
  irq_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> !pin_drive_low);

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);
endmodule

bind rc_wake_timer_reg rcw_wake_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .REG_ADDR(REG_ADDR)
) u_wake_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_wdata     (io_wdata),
  .pin_drive_low(pin_drive_low),
  .wake_irq     (wake_irq)
);

// File: tb/test_rc_wake_timer_reg.sv
`timescale 1ns/1ps
module test_rc_wake_timer_reg;
  localparam logic [7:0] A_REG = 8'h22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       pin_in;
  logic       pin_drive_low;
  logic       wake_irq;
  logic       wake_req;

  int total = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit done = 0;

  // Pin environment: pull-down drains at once, resistor charges after a delay
  int   charge_cyc = 20;
  int   chg = 20;
  logic pin_lvl = 1'b1;
  logic glitch = 1'b0;
  assign pin_in = pin_lvl | glitch;

  always #2 clk = ~clk;

  rc_wake_timer_reg i_rc_wake_timer_reg (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pin_in(pin_in),
    .pin_drive_low(pin_drive_low), .wake_irq(wake_irq), .wake_req(wake_req)
  );

  always @(negedge clk) begin
    if (pin_drive_low) begin
      chg = 0;
      pin_lvl = 1'b0;
    end else if (chg < charge_cyc) begin
      chg++;
    end else begin
      pin_lvl = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin sample history, newest first
  bit hist[$] = '{1'b1, 1'b1, 1'b1};
  bit rel_m = 1'b1;

  always @(posedge clk) begin
    bit         e_irq;
    logic [7:0] e_rd;
    if (!rst_n) begin
      hist = '{1'b1, 1'b1, 1'b1};
      rel_m = 1'b1;
    end else begin
      if (io_wr && io_addr == A_REG) rel_m = io_wdata[0];
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
    e_irq = rel_m && hist[1] && !hist[2];
    e_rd  = (io_rd && io_addr == A_REG) ? {7'b0, hist[1]} : 8'h00;
    #1;
    chk("R2/R3 drive", {7'b0, pin_drive_low}, {7'b0, !rel_m});
    chk("R7/R8 irq", {7'b0, wake_irq}, {7'b0, e_irq});
    chk("R9 req", {7'b0, wake_req}, {7'b0, wake_irq});
    chk("R5/R6 rdata", io_rdata, e_rd);
    if (wake_irq) irq_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 chk(req, io_rdata, exp);
    @(negedge clk);
    io_rd = 1'b0; io_addr = 8'h00;
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    tick(3);
    chk("R1 reset drive", {7'b0, pin_drive_low}, 8'h00);
    chk("R1 reset irq", {7'b0, wake_irq}, 8'h00);
    rst_n = 1'b1;
    tick(2);
    chk("R1 after reset drive", {7'b0, pin_drive_low}, 8'h00);
    rd_chk("R1 R5 reset level", A_REG, 8'h01);

    // Discharge
    wr(A_REG, 8'h00);
    chk("R2 discharge on", {7'b0, pin_drive_low}, 8'h01);
    tick(4);
    rd_chk("R5 low level", A_REG, 8'h00);

    // Glitch high while discharging must not interrupt
    irq_cnt = 0;
    glitch = 1'b1; tick(4); glitch = 1'b0; tick(4);
    chk("R8 no irq during discharge", irq_cnt[7:0], 8'h00);

    // Other addresses and upper bits ignored
    wr(8'h23, 8'hFF);
    wr(8'h21, 8'h01);
    chk("R4 other address", {7'b0, pin_drive_low}, 8'h01);
    wr(A_REG, 8'hFE);
    chk("R4 upper bits ignored", {7'b0, pin_drive_low}, 8'h01);
    rd_chk("R6 other address read", 8'h23, 8'h00);

    // Release and charge
    irq_cnt = 0;
    wr(A_REG, 8'h01);
    chk("R3 release", {7'b0, pin_drive_low}, 8'h00);
    tick(30);
    chk("R7 one wake pulse", irq_cnt[7:0], 8'h01);
    rd_chk("R5 high level", A_REG, 8'h01);

    // Releasing again with pin already high gives no pulse
    irq_cnt = 0;
    wr(A_REG, 8'h03);
    tick(6);
    chk("R7 no pulse without low", irq_cnt[7:0], 8'h00);

    // Shorter charge delay, several periods
    charge_cyc = 7;
    for (int k = 0; k < 3; k++) begin
      irq_cnt = 0;
      wr(A_REG, 8'h00);
      tick(5);
      wr(A_REG, 8'h01);
      tick(15);
      chk("R7 R10 periodic pulse", irq_cnt[7:0], 8'h01);
    end

    // Brief discharge then glitch-free release
    irq_cnt = 0;
    wr(A_REG, 8'h00);
    wr(A_REG, 8'h01);
    tick(15);
    chk("R7 short discharge pulse", irq_cnt[7:0], 8'h01);

    done = 1;
    finish_run();
  end
endmodule